// File: doc/BRIEF.md
# Cycle Slip Detector for a Phase-Frequency Detector

This block rebuilds the state of a tri-state phase-frequency detector inside a fast sampling clock domain and watches it for cycle slips. The reference clock and the divided feedback clock enter as asynchronous levels. Each one passes through its own synchronizer and rising-edge detector. The up/down state then follows those edges. A slip is an edge that arrives on an input whose detector output is still asserted from that input's previous edge. It means the phase error has wrapped past a full cycle, which only happens while a frequency offset is present. The loop stays closed throughout.

At every slip the block raises a single-cycle `update` strobe. This strobe is the only trigger for a downstream coarse-tuning calibration engine. In the same cycle the block presents `sign`, which gives the direction of the offset. While the detector stays in its linear range, edges simply alternate and no strobe appears. After a programmable count of reference edges pass with no slip, `locked` rises so that the calibration logic can gate itself off. Detection keeps running after lock, so a later frequency drift produces slips again and restarts calibration.

Top module: `cslip_detector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pfd_up`, `pfd_dn`, `update`, `sign` and `locked` are all 0.
- R2: When a reference rising edge arrives alone and both `pfd_up` and `pfd_dn` are low, `pfd_up` goes high. The new state appears three sampling clocks after the first sampling edge that sees the new input level.
- R3: When a lone edge arrives on the opposite input while one detector output is high, that output clears and no `update` is produced. `pfd_up` and `pfd_dn` are never high together.
- R4: When a lone reference edge arrives while `pfd_up` is already high, the block produces an `update` with `sign` = 0 (reference leads), and `pfd_up` stays high.
- R5: When a lone feedback edge arrives while `pfd_dn` is already high, the block produces an `update` with `sign` = 1 (feedback leads), and `pfd_dn` stays high.
- R6: `update` is exactly one sampling clock wide.
- R7: When reference and feedback rising edges are detected in the same sampling cycle, `pfd_up` and `pfd_dn` keep their values and no `update` is produced.
- R8: `sign` changes only in a cycle where `update` is high. Between strobes it holds the polarity of the last slip.
- R9: `locked` rises on the reference edge that brings the count of reference edges since the last slip (or since reset) to `lock_cycles`. A value of 0 acts as 1. `locked` clears in the same cycle as the next `update`.
- R10: Slips are still detected and strobed while `locked` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_in | input | 1 | Reference clock level, asynchronous to `clk` |
| fb_clk_in | input | 1 | Divided feedback clock level, asynchronous to `clk` |
| lock_cycles | input | CNT_W | Slip-free reference edges needed before `locked` |
| pfd_up | output | 1 | Modelled detector up output |
| pfd_dn | output | 1 | Modelled detector down output |
| update | output | 1 | One-cycle strobe at each cycle slip |
| sign | output | 1 | Offset polarity, 0 = reference leads, valid with `update` |
| locked | output | 1 | No slip within the programmed window; calibration may idle |

## Verification
The assertions assume that every high phase and every low phase of both input clocks lasts at least three sampling clocks. This guarantees that each rising edge is detected exactly once. It also means the two edge pulses of one input can never fall in adjacent cycles. The bench holds each input level for three cycles, then holds it low for three more, before it starts the next event. Every event is a reference edge, a feedback edge or a coincident pair. `lock_cycles` is changed only while reset is held, because the assertions and the bench model treat it as static.

// File: rtl/cslip_pkg.sv
package cslip_pkg;

  typedef struct packed {
    logic up;
    logic dn;
    logic slip_up;
    logic slip_dn;
  } pfd_step_t;

  // Next tri-state detector state for one sampling cycle of edge pulses.
  function automatic pfd_step_t pfd_step(input logic up, input logic dn,
                                         input logic r, input logic f);
    pfd_step_t s;
    s.up      = up;
    s.dn      = dn;
    s.slip_up = 1'b0;
    s.slip_dn = 1'b0;
    if (r && !f) begin
      if (dn)      s.dn      = 1'b0;
      else if (up) s.slip_up = 1'b1;
      else         s.up      = 1'b1;
    end else if (f && !r) begin
      if (up)      s.up      = 1'b0;
      else if (dn) s.slip_dn = 1'b1;
      else         s.dn      = 1'b1;
    end
    return s;
  endfunction

endpackage

// File: rtl/cslip_edge_sync.sv
module cslip_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[DEPTH-2:0], async_in};
  end

  assign rise = shift_q[DEPTH-2] & ~shift_q[DEPTH-1];

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6

endmodule

// File: rtl/cslip_pfd_core.sv
module cslip_pfd_core
  import cslip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up,
  output logic dn,
  output logic update,
  output logic sign,
  output logic slip_evt
);
  pfd_step_t nx;
  logic up_q, dn_q, upd_q, sign_q;

  always_comb nx = pfd_step(up_q, dn_q, ref_rise, fb_rise);

  assign slip_evt = nx.slip_up | nx.slip_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      upd_q  <= 1'b0;
      sign_q <= 1'b0;
    end else begin
      up_q  <= nx.up;
      dn_q  <= nx.dn;
      upd_q <= slip_evt;
      if (slip_evt) sign_q <= dn_q; // down state sampled at the slip
    end
  end

  assign up     = up_q;
  assign dn     = dn_q;
  assign update = upd_q;
  assign sign   = sign_q;

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q)); // R3
  AST_UP_SLIP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && up_q) |=> (upd_q && !sign_q && up_q)); // R4
  AST_DN_SLIP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && dn_q) |=> (upd_q && sign_q && dn_q)); // R5
  AST_COINCIDENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> ($stable(up_q) && $stable(dn_q) && !upd_q)); // R7
  AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(sign_q)); // R8

endmodule

// File: rtl/cslip_lock_timer.sv
module cslip_lock_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             slip,
  input  logic [CNT_W-1:0] lock_cycles,
  output logic             locked
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             locked_q;

  assign cnt_inc = sat_inc(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (slip) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (ref_rise) begin
      cnt_q <= cnt_inc;
      if (cnt_inc >= lock_cycles) locked_q <= 1'b1;
    end
  end

  assign locked = locked_q;

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !locked_q); // R9
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !slip) |=> (cnt_q == CNT_MAX)); // R9

endmodule

// File: rtl/cslip_detector.sv
module cslip_detector #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_in,
  input  logic             fb_clk_in,
  input  logic [CNT_W-1:0] lock_cycles,
  output logic             pfd_up,
  output logic             pfd_dn,
  output logic             update,
  output logic             sign,
  output logic             locked
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] clk_lvl;
  logic [N_IN-1:0] rise_vec;
  logic            slip_evt;

  assign clk_lvl = {fb_clk_in, ref_clk_in};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    cslip_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (clk_lvl[i]),
      .rise     (rise_vec[i])
    );
  end

  cslip_pfd_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (rise_vec[0]),
    .fb_rise  (rise_vec[1]),
    .up       (pfd_up),
    .dn       (pfd_dn),
    .update   (update),
    .sign     (sign),
    .slip_evt (slip_evt)
  );

  cslip_lock_timer #(.CNT_W(CNT_W)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_rise    (rise_vec[0]),
    .slip        (slip_evt),
    .lock_cycles (lock_cycles),
    .locked      (locked)
  );

  AST_UPDATE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> !locked); // R9
  AST_DETECT_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && slip_evt) |=> update); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!update && !pfd_up && !pfd_dn && !locked)); // R1

endmodule

// File: tb/sim_cslip_detector.sv
module sim_cslip_detector;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic [CW-1:0] lock_cycles = 16'd5;
  logic pfd_up, pfd_dn, update, sign, locked;

  int checks = 0;
  int errors = 0;
  int upd_count = 0;
  int upd_run = 0;
  int upd_max = 0;

  // bench model: phase lead in whole edges, clipped to one either way
  int lead = 0;
  int ref_since = 0;
  int exp_upd = 0;
  int exp_sign = 0;
  int lock_need = 5;

  always #5 clk = ~clk;

  cslip_detector #(.SYNC_STAGES(2), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_in), .fb_clk_in(fb_in),
    .lock_cycles(lock_cycles), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .update(update), .sign(sign), .locked(locked)
  );

  always @(negedge clk) begin
    if (update) begin
      upd_count = upd_count + 1;
      upd_run = upd_run + 1;
      if (upd_run > upd_max) upd_max = upd_run;
    end else begin
      upd_run = 0;
    end
  end

  function automatic int need_of(input int l);
    return (l < 1) ? 1 : l;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input int l);
    rst_n = 1'b0;
    ref_in = 1'b0;
    fb_in = 1'b0;
    lock_cycles = l[CW-1:0];
    repeat (3) @(negedge clk);
    chk("R1", "update in reset", int'(update), 0);
    chk("R1", "up/dn in reset", int'({pfd_up, pfd_dn}), 0);
    chk("R1", "locked in reset", int'(locked), 0);
    rst_n = 1'b1;
    lead = 0;
    ref_since = 0;
    exp_sign = 0;
    lock_need = need_of(l);
    @(negedge clk);
    chk("R1", "sign after reset", int'(sign), 0);
    exp_upd = upd_count;
  endtask

  task automatic ev(input bit r, input bit f, input string tag);
    bit slipped;
    @(negedge clk);
    ref_in = r;
    fb_in = f;
    repeat (3) @(negedge clk);
    ref_in = 1'b0;
    fb_in = 1'b0;
    repeat (3) @(negedge clk);
    slipped = 1'b0;
    if (r && !f) begin
      if (lead == 1) begin slipped = 1'b1; exp_sign = 0; end
      else lead = lead + 1;
    end else if (f && !r) begin
      if (lead == -1) begin slipped = 1'b1; exp_sign = 1; end
      else lead = lead - 1;
    end
    if (slipped) begin
      exp_upd = exp_upd + 1;
      ref_since = 0;
    end else if (r) begin
      ref_since = ref_since + 1;
    end
    chk(tag, "update count", upd_count, exp_upd);
    chk(tag, "pfd_up", int'(pfd_up), (lead == 1) ? 1 : 0);
    chk(tag, "pfd_dn", int'(pfd_dn), (lead == -1) ? 1 : 0);
    chk(tag, "sign", int'(sign), exp_sign);
    chk(tag, "locked", int'(locked), (ref_since >= lock_need) ? 1 : 0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    do_reset(100);
    ev(1, 0, "R2");
    ev(0, 1, "R3");
    ev(1, 0, "R2");
    ev(1, 0, "R4");
    ev(1, 0, "R4");
    ev(0, 1, "R3");
    ev(0, 1, "R5");
    ev(0, 1, "R5");
    ev(1, 1, "R7");
    ev(1, 0, "R8");
    ev(1, 1, "R7");
    ev(0, 1, "R8");

    do_reset(4);
    for (int i = 0; i < 4; i++) begin
      ev(1, 0, "R9");
      ev(0, 1, "R9");
    end
    chk("R9", "locked after window", int'(locked), 1);
    ev(1, 0, "R10");
    ev(1, 0, "R10");
    chk("R10", "locked after slip", int'(locked), 0);

    do_reset(0);
    ev(1, 0, "R9");
    chk("R9", "zero window locks on one edge", int'(locked), 1);

    do_reset(7);
    for (int i = 0; i < 400; i++) begin
      int pick;
      pick = int'($urandom % 8);
      if (pick < 3 || pick == 7) ev(1, 0, "R10");
      else if (pick < 6)         ev(0, 1, "R10");
      else                       ev(1, 1, "R7");
    end

    chk("R6", "widest update pulse", upd_max, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule